// File: doc/BRIEF.md
# Wear-Adaptive Refresh Interval Scheduler

This block decides when each flash block is due for a read-correct-rewrite refresh pass. It sweeps all blocks in round-robin order. For the block under its pointer it reads the program/erase count from a lookup port and picks a refresh interval from a configurable wear table. A block with little wear is never refreshed. As the count climbs, the block gets shorter and shorter intervals, so that the raw error rate stays inside what a weak error-correcting code can repair. With the intended table the steps run from a three-year interval down to a one-day interval.

A free-running time counter advances on a slow tick input. Each block keeps the time of its last completed refresh. When a block falls due, the scheduler issues one request per page, for every page of the block. Each request waits for its own acknowledge. A temperature flag halves the selected interval, and the result never goes below the table's shortest interval. The timestamp is written only when the final page is acknowledged.

Top module: `refresh_sched`

## Requirements
- R1: After reset `req_valid` is 0, `lookup_blk` is 0, the time count is 0 and every block's last-refresh time is 0.
- R2: The wear table holds thresholds in ascending order in `thr_tbl`, with entry i at bits [i*PE_W +: PE_W], and the matching intervals in `ivl_tbl`, laid out the same way with TIME_W-bit fields. The selected interval is the one paired with the highest threshold that is less than or equal to the block's count.
- R3: A block whose count is below `thr_tbl` entry 0 is never requested, however much time passes.
- R4: A block is due when (time − last-refresh time) is greater than or equal to its selected interval. One tick less than that gives no request.
- R5: A due block is requested page by page, from page 0 up to PAGES−1 in ascending order. Each page is held on `req_blk`/`req_page` with `req_valid` high until `req_ack` is seen.
- R6: Only one request is outstanding at a time. `lookup_blk` and `req_blk` stay fixed until the final page is acknowledged. `req_valid` drops in the cycle after that final acknowledge.
- R7: The last-refresh time of a block is set to the current time when its final page is acknowledged. The block becomes due again exactly one interval later.
- R8: While `hot` is 1, the interval is half the selected one. It is never less than the interval of the last table entry.
- R9: Blocks are examined in ascending index order, wrapping from NUM_BLOCKS−1 to 0. With several blocks due at once, they are served in that cyclic order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base pulse; each cycle it is high advances the time count by one |
| hot | input | 1 | High temperature: halve the interval |
| thr_tbl | input | NUM_LEVELS*PE_W | Ascending wear thresholds |
| ivl_tbl | input | NUM_LEVELS*TIME_W | Interval for each threshold, in ticks |
| lookup_blk | output | BLK_W | Block whose wear count is wanted |
| lookup_pe | input | PE_W | Wear count of `lookup_blk`, valid in the same cycle |
| req_valid | output | 1 | Page refresh request pending |
| req_blk | output | BLK_W | Block of the pending request |
| req_page | output | PAGE_W | Page of the pending request |
| req_ack | input | 1 | Acknowledge of the pending page |

## Verification
A corrupted timestamp or time count shows up at the ports as a request that starts one tick too early or too late. So the bench probes each interval on both sides of its boundary, then again one interval after the refresh finishes. A wrong level decode or a wrong temperature scaling shifts that first request by a whole step of the table, and is visible within one sweep of the blocks. A page or pointer error shows up on the very next acknowledge, as a skipped page, a changed block, or a request that fails to drop.

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int NUM_BLOCKS = 8,
  parameter int PAGES      = 128,
  parameter int NUM_LEVELS = 6,
  parameter int PE_W       = 16,
  parameter int TIME_W     = 16,
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int PAGE_W    = $clog2(PAGES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         hot,
  input  logic [NUM_LEVELS*PE_W-1:0]   thr_tbl,
  input  logic [NUM_LEVELS*TIME_W-1:0] ivl_tbl,
  output logic [BLK_W-1:0]             lookup_blk,
  input  logic [PE_W-1:0]              lookup_pe,
  output logic                         req_valid,
  output logic [BLK_W-1:0]             req_blk,
  output logic [PAGE_W-1:0]            req_page,
  input  logic                         req_ack
);
  localparam logic [PAGE_W-1:0] LAST_PG = PAGE_W'(PAGES - 1);
  localparam logic [BLK_W-1:0]  LAST_BK = BLK_W'(NUM_BLOCKS - 1);

  logic [TIME_W-1:0] now;
  logic [TIME_W-1:0] stamp [NUM_BLOCKS];
  logic [BLK_W-1:0]  ptr;
  logic [PAGE_W-1:0] page;
  logic              busy;

  logic              lvl_hit;
  logic [TIME_W-1:0] base_ivl, half_ivl, eff_ivl, elapsed, floor_ivl;
  logic              due, final_ack;

  always_comb begin
    lvl_hit  = 1'b0;
    base_ivl = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (lookup_pe >= thr_tbl[i*PE_W +: PE_W]) begin
        lvl_hit  = 1'b1;
        base_ivl = ivl_tbl[i*TIME_W +: TIME_W];
      end
    end
  end

  assign floor_ivl = ivl_tbl[(NUM_LEVELS-1)*TIME_W +: TIME_W];
  assign half_ivl  = base_ivl >> 1;
  assign eff_ivl   = !hot ? base_ivl : (half_ivl < floor_ivl ? floor_ivl : half_ivl);
  assign elapsed   = now - stamp[ptr];
  assign due       = lvl_hit && (elapsed >= eff_ivl);
  assign final_ack = busy && req_ack && (page == LAST_PG);

  always_ff @(posedge clk) begin
    if (!rst_n) now <= '0;
    else if (tick) now <= now + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ptr  <= '0;
      page <= '0;
      for (int b = 0; b < NUM_BLOCKS; b++) stamp[b] <= '0;
    end else if (!busy) begin
      if (due) begin
        busy <= 1'b1;
        page <= '0;
      end else begin
        ptr <= (ptr == LAST_BK) ? '0 : ptr + 1'b1;
      end
    end else if (req_ack) begin
      if (page == LAST_PG) begin
        busy       <= 1'b0;
        stamp[ptr] <= now;
        ptr        <= (ptr == LAST_BK) ? '0 : ptr + 1'b1;
      end else begin
        page <= page + 1'b1;
      end
    end
  end

  assign lookup_blk = ptr;
  assign req_valid  = busy;
  assign req_blk    = ptr;
  assign req_page   = page;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ack |=> req_valid && $stable(req_blk) && $stable(req_page)); // R5
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ack && req_page != LAST_PG |=> req_valid && req_page == $past(req_page) + 1'b1); // R5
  AST_FIRST_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> req_page == '0); // R5
  AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !final_ack |=> req_valid && $stable(lookup_blk)); // R6
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    final_ack |=> !req_valid); // R6
  AST_NO_START_UNDUE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid && !due |=> !req_valid); // R4
endmodule

// File: tb/test_refresh_sched.sv
module test_refresh_sched;
  localparam int NB = 8, NP = 128, NL = 6, PW = 16, TW = 16;
  localparam int BW = $clog2(NB), GW = $clog2(NP);
  localparam int TGT = 3;

  logic clk = 0, rst_n = 0, tick = 0, hot = 0, req_ack = 0;
  logic [NL*PW-1:0] thr_tbl;
  logic [NL*TW-1:0] ivl_tbl;
  logic [BW-1:0] lookup_blk, req_blk;
  logic [GW-1:0] req_page;
  logic [PW-1:0] lookup_pe;
  logic req_valid;
  logic [PW-1:0] pe_mem [NB];

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  assign thr_tbl = {16'd600, 16'd500, 16'd400, 16'd300, 16'd200, 16'd100};
  assign ivl_tbl = {16'd4, 16'd10, 16'd40, 16'd100, 16'd200, 16'd400};
  assign lookup_pe = pe_mem[lookup_blk];

  refresh_sched #(.NUM_BLOCKS(NB), .PAGES(NP), .NUM_LEVELS(NL), .PE_W(PW), .TIME_W(TW)) i_refresh_sched (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hot(hot), .thr_tbl(thr_tbl), .ivl_tbl(ivl_tbl),
    .lookup_blk(lookup_blk), .lookup_pe(lookup_pe), .req_valid(req_valid), .req_blk(req_blk),
    .req_page(req_page), .req_ack(req_ack));

  // {wear count, hot, expected interval (0 = never)}
  localparam logic [32:0] VEC [14] = '{
    {16'd50,   1'b0, 16'd0},   {16'd99,  1'b0, 16'd0},
    {16'd100,  1'b0, 16'd400}, {16'd150, 1'b0, 16'd400},
    {16'd200,  1'b0, 16'd200}, {16'd350, 1'b0, 16'd100},
    {16'd450,  1'b0, 16'd40},  {16'd599, 1'b0, 16'd10},
    {16'd600,  1'b0, 16'd4},   {16'd9000,1'b0, 16'd4},
    {16'd200,  1'b1, 16'd100}, {16'd450, 1'b1, 16'd20},
    {16'd550,  1'b1, 16'd5},   {16'd600, 1'b1, 16'd4}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; tick = 0; req_ack = 0;
    wait_cyc(2);
    rst_n = 1;
  endtask

  task automatic advance(input int n);
    if (n > 0) begin
      tick = 1; wait_cyc(n); tick = 0;
    end
    wait_cyc(12);
  endtask

  task automatic serve(input int blk, input string tag);
    int bad = 0;
    for (int p = 0; p < NP; p++) begin
      if (!req_valid || req_blk != BW'(blk) || req_page != GW'(p)) bad++;
      req_ack = 1; wait_cyc(1); req_ack = 0;
    end
    chk(bad == 0, {tag, " R5 page sequence"}, bad, 0);
    chk(!req_valid, {tag, " R6 release after last page"}, int'(req_valid), 0);
  endtask

  initial begin
    for (int b = 0; b < NB; b++) pe_mem[b] = '0;
    do_reset();
    chk(!req_valid && lookup_blk == 0, "R1 reset state", int'(req_valid), 0);
    wait_cyc(1);
    chk(lookup_blk == 1, "R9 sweep advances past idle block", int'(lookup_blk), 1);

    for (int v = 0; v < 14; v++) begin
      int ivl;
      ivl = int'(VEC[v][15:0]);
      for (int b = 0; b < NB; b++) pe_mem[b] = '0;
      pe_mem[TGT] = VEC[v][32:17];
      hot = VEC[v][16];
      do_reset();
      if (ivl == 0) begin
        advance(1000);
        chk(!req_valid, "R3 low wear never requested", int'(req_valid), 0);
      end else begin
        advance(ivl - 1);
        chk(!req_valid, hot ? "R8 one tick before halved interval" : "R4 R2 one tick before interval",
            int'(req_valid), 0);
        advance(1);
        chk(req_valid && req_blk == TGT, hot ? "R8 due at halved interval" : "R4 R2 due at interval",
            int'(req_valid), 1);
        serve(TGT, "vec");
        advance(ivl - 1);
        chk(!req_valid, "R7 not due before interval after refresh", int'(req_valid), 0);
        advance(1);
        chk(req_valid && req_blk == TGT, "R7 due one interval after refresh", int'(req_valid), 1);
      end
    end

    hot = 0;
    for (int b = 0; b < NB; b++) pe_mem[b] = '0;
    pe_mem[2] = 16'd700; pe_mem[5] = 16'd700; pe_mem[6] = 16'd700;
    do_reset();
    advance(4);
    chk(req_valid, "R9 request with three due blocks", int'(req_valid), 1);
    begin
      int first, nxt, third;
      first = int'(req_blk);
      chk(first == 2 || first == 5 || first == 6, "R9 first is a due block", first, 2);
      req_ack = 0;
      wait_cyc(5);
      chk(req_valid && int'(req_blk) == first && req_page == 0 && int'(lookup_blk) == first,
          "R6 hold without ack", int'(req_blk), first);
      serve(first, "rr1");
      nxt = (first == 2) ? 5 : (first == 5) ? 6 : 2;
      third = (nxt == 2) ? 5 : (nxt == 5) ? 6 : 2;
      wait_cyc(12);
      chk(req_valid && int'(req_blk) == nxt, "R9 second in cyclic order", int'(req_blk), nxt);
      serve(nxt, "rr2");
      wait_cyc(12);
      chk(req_valid && int'(req_blk) == third, "R9 third in cyclic order", int'(req_blk), third);
      serve(third, "rr3");
      wait_cyc(12);
      chk(!req_valid, "R7 all served, none due", int'(req_valid), 0);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule